// File: doc/BRIEF.md
# Two-Port Shared Mailbox Memory

This block is a 1024-by-8 shared memory. Two independent agents, port A and port B, can each read and write it, and both share one clock. Each port has its own select, read strobe, write strobe, address and write data. Each port also has its own registered read data. When the two ports select different locations, both accesses complete in the same cycle.

When both ports select the same location, an arbiter lets one port through. It raises a combinational busy line to the other port, which that agent uses as a wait signal. The stalled port holds its request. Its access completes in the first cycle after the winning port lets go of the location.

The two highest locations also act as doorbells, one for each direction. A write by one side stores the byte as usual and raises an active-low interrupt to the other side. The receiving side clears that interrupt by reading the same location, and it finds the message byte there.

Top module: `mailbox_dpram`

## Requirements
- R1: A granted write stores the write data at the address. A granted read presents the stored byte on that port's read data after the next rising clock edge. Read data holds its value while no read is granted.
- R2: When both ports are selected at different addresses, neither busy output is asserted, and both accesses complete in the same cycle.
- R3: When both ports select the same address, the port that was already selected in the previous cycle wins. The other port's busy is asserted in the same cycle, and its access does not take effect.
- R4: When both ports newly select the same address in the same cycle, port A wins and only b_busy is asserted.
- R5: The loser's busy stays asserted for as long as the winner keeps selecting that address. In the first cycle after the winner deselects, the loser's busy drops and its access completes.
- R6: A port A write to address 0x3FF stores the byte and drives b_irq_n low after the next rising edge. A port B write to address 0x3FE stores the byte and drives a_irq_n low after the next rising edge.
- R7: A port B read of 0x3FF returns the stored byte and releases b_irq_n high after that edge. A port A read of 0x3FF leaves b_irq_n low.
- R8: A port A read of 0x3FE releases a_irq_n high. A port B read of 0x3FE leaves a_irq_n low.
- R9: During reset (rst_n low, sampled on the rising edge), both busy outputs are low. After a reset edge, both interrupt outputs are high. Reset does not initialise the memory contents.
- R10: a_busy and b_busy are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_sel | input | 1 | Port A select |
| a_rd | input | 1 | Port A read strobe |
| a_wr | input | 1 | Port A write strobe |
| a_addr | input | 10 | Port A address |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A registered read data |
| a_busy | output | 1 | Port A must wait (lost a same-address contest) |
| a_irq_n | output | 1 | Active-low interrupt to A, raised by a B write to 0x3FE |
| b_sel | input | 1 | Port B select |
| b_rd | input | 1 | Port B read strobe |
| b_wr | input | 1 | Port B write strobe |
| b_addr | input | 10 | Port B address |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B registered read data |
| b_busy | output | 1 | Port B must wait (lost a same-address contest) |
| b_irq_n | output | 1 | Active-low interrupt to B, raised by an A write to 0x3FF |

## Verification
A long seeded random phase drives both ports every cycle with mixed reads, writes and idle slots at distinct addresses below the doorbells. It shows that parallel traffic never raises busy and that no port corrupts the other's data. Directed contests cover the three arbitration cases: A first, B first and a same-cycle tie. In each case the final memory value and the loser's read data show whether the stalled access was held back and then completed, rather than dropped or applied early. The doorbell sequences read each location from both sides, which separates the clearing read by the receiver from the harmless read by the sender. A reset taken while an interrupt is pending shows that the flags return high.

// File: rtl/mailbox_dpram_pkg.sv
// Package: shared types for the two-port mailbox memory.
// Assumes: both ports run on one clock.
package mailbox_dpram_pkg;

    // Which port currently holds a contested location.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;

endpackage

// File: rtl/mbx_arbiter.sv
// Module: mbx_arbiter
// Decides which port may touch the memory in each cycle. Different
// addresses are both granted. On the same address, the port already
// selected last cycle wins; on a tie, A wins. The winner keeps the
// location until it deselects or moves away.
// Assumes: a requester that sees busy holds its address and strobes.
module mbx_arbiter
    import mailbox_dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_req,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_grant,
    output logic              b_grant,
    output logic              a_busy,
    output logic              b_busy
);

    logic   a_prev_q, b_prev_q;
    owner_e owner_q, owner_d;
    logic   clash;
    logic   b_wins;

    // Detect two selects on one location.
    always_comb begin
        clash = a_req && b_req && (a_addr == b_addr);
    end

    // Pick the winner of a clash: held owner first, then earlier select, then A.
    always_comb begin
        if (owner_q == OWN_B)
            b_wins = 1'b1;
        else if (owner_q == OWN_A)
            b_wins = 1'b0;
        else
            b_wins = b_prev_q && !a_prev_q;
        owner_d = clash ? (b_wins ? OWN_B : OWN_A) : OWN_NONE;
    end

    // Busy and grant outputs; busy is forced low during reset.
    always_comb begin
        a_busy  = rst_n && clash && b_wins;
        b_busy  = rst_n && clash && !b_wins;
        a_grant = rst_n && a_req && !a_busy;
        b_grant = rst_n && b_req && !b_busy;
    end

    // Remember previous selects and the current owner of a contested location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev_q <= 1'b0;
            b_prev_q <= 1'b0;
            owner_q  <= OWN_NONE;
        end else begin
            a_prev_q <= a_req;
            b_prev_q <= b_req;
            owner_q  <= owner_d;
        end
    end

    // R10: the two busy lines exclude each other.
    a_r10_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_busy && b_busy));

    // R2: distinct addresses never stall.
    a_r2_parallel_free: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && a_addr != b_addr) |-> (!a_busy && !b_busy));

    // R4: a same-cycle tie goes to A.
    a_r4_tie_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && a_addr == b_addr && !$past(a_req) && !$past(b_req))
        |-> (b_busy && !a_busy));

    // R3: an earlier B select keeps the location against a newcomer A.
    a_r3_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && a_addr == b_addr && $past(b_req) && !$past(a_req)
         && !$past(a_busy)) |-> a_busy);

    // R5: a loser stays stalled while the clash persists.
    a_r5_loser_held: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && $past(clash) && $past(b_busy)) |-> b_busy);

endmodule

// File: rtl/mbx_storage.sv
// Module: mbx_storage
// The memory array with two synchronous ports. A read returns the old
// byte, registered. Read data holds when no read is enabled.
// Assumes: the arbiter never enables two writes to one address.
module mbx_storage #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Apply granted writes from both ports (contents are never reset).
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
    end

    // Register read data for each port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_re) a_rdata <= mem[a_addr];
            if (b_re) b_rdata <= mem[b_addr];
        end
    end

    // R1: granted writes never collide on one address.
    a_r1_no_double_write: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we) |-> (a_addr != b_addr));

endmodule

// File: rtl/mbx_doorbell.sv
// Module: mbx_doorbell
// One interrupt flag. A sender's granted write to the doorbell address
// raises it. The receiver's granted read of that address clears it.
// The output is active-low.
// Assumes: the set and clear strobes arrive already qualified by grants.
module mbx_doorbell #(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] BELL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_wr,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic              rcv_rd,
    input  logic [ADDR_W-1:0] rcv_addr,
    output logic              irq_n
);

    logic flag_q;
    logic ring, ack;

    // Decode ring (sender write) and acknowledge (receiver read).
    always_comb begin
        ring = snd_wr && (snd_addr == BELL_ADDR);
        ack  = rcv_rd && (rcv_addr == BELL_ADDR);
    end

    // Hold the pending flag; a ring wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (ring) flag_q <= 1'b1;
        else if (ack)  flag_q <= 1'b0;
    end

    // Drive the active-low interrupt.
    always_comb begin
        irq_n = !flag_q;
    end

    // R6: a ring shows on the interrupt one edge later.
    a_r6_ring_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ring |=> !irq_n);

    // R7: without an acknowledge, a pending interrupt stays.
    a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !ack) |=> !irq_n);

    // R8: an acknowledge without a ring releases the interrupt.
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ring) |=> irq_n);

endmodule

// File: rtl/mailbox_dpram.sv
// Module: mailbox_dpram (top)
// Two-port shared memory with same-address arbitration, busy outputs,
// and two doorbell interrupts at the top two addresses.
// Assumes: one shared clock; synchronous active-low reset; stalled
// agents hold their request while busy is high.
module mailbox_dpram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_rd,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_busy,
    output logic              a_irq_n,
    input  logic              b_sel,
    input  logic              b_rd,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_busy,
    output logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] BELL_TO_B = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BELL_TO_A = BELL_TO_B - 1'b1;

    logic a_grant, b_grant;
    logic a_we, a_re, b_we, b_re;

    mbx_arbiter #(.ADDR_W(ADDR_W)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_req   (a_sel),
        .a_addr  (a_addr),
        .b_req   (b_sel),
        .b_addr  (b_addr),
        .a_grant (a_grant),
        .b_grant (b_grant),
        .a_busy  (a_busy),
        .b_busy  (b_busy)
    );

    // Qualify the strobes with the grants.
    always_comb begin
        a_we = a_grant && a_wr;
        a_re = a_grant && a_rd;
        b_we = b_grant && b_wr;
        b_re = b_grant && b_rd;
    end

    mbx_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (a_we),
        .a_re    (a_re),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_we    (b_we),
        .b_re    (b_re),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    // Doorbell A->B: A writes, B reads.
    mbx_doorbell #(.ADDR_W(ADDR_W), .BELL_ADDR(BELL_TO_B)) i_bell_to_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .snd_wr   (a_we),
        .snd_addr (a_addr),
        .rcv_rd   (b_re),
        .rcv_addr (b_addr),
        .irq_n    (b_irq_n)
    );

    // Doorbell B->A: B writes, A reads.
    mbx_doorbell #(.ADDR_W(ADDR_W), .BELL_ADDR(BELL_TO_A)) i_bell_to_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .snd_wr   (b_we),
        .snd_addr (b_addr),
        .rcv_rd   (a_re),
        .rcv_addr (a_addr),
        .irq_n    (a_irq_n)
    );

    // R9: busy is low while reset is applied.
    a_r9_reset_busy: assert property (@(posedge clk)
        !rst_n |-> (!a_busy && !b_busy));

    // R9: both interrupts are released after a reset edge.
    a_r9_reset_irq: assert property (@(posedge clk)
        !rst_n |=> (a_irq_n && b_irq_n));

endmodule

// File: tb/test_mailbox_dpram.sv
module test_mailbox_dpram;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_sel, a_rd, a_wr, b_sel, b_rd, b_wr;
    logic [9:0] a_addr, b_addr;
    logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic       a_busy, b_busy, a_irq_n, b_irq_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    logic [7:0] mdl   [1024];
    bit         known [1024];

    always #4 clk = ~clk;

    mailbox_dpram i_mailbox_dpram (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_busy(a_busy), .a_irq_n(a_irq_n),
        .b_sel(b_sel), .b_rd(b_rd), .b_wr(b_wr), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_busy(b_busy), .b_irq_n(b_irq_n)
    );

    function automatic logic [7:0] expect_rd(input logic [9:0] ad);
        return mdl[ad];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        a_sel = 0; a_rd = 0; a_wr = 0; a_addr = 0; a_wdata = 0;
        b_sel = 0; b_rd = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    endtask

    // One single-port access on A or B, with all the other inputs idle.
    task automatic port_op(input bit on_b, input bit wr, input logic [9:0] ad, input logic [7:0] d);
        @(negedge clk);
        idle_all();
        if (!on_b) begin a_sel = 1; a_rd = !wr; a_wr = wr; a_addr = ad; a_wdata = d; end
        else       begin b_sel = 1; b_rd = !wr; b_wr = wr; b_addr = ad; b_wdata = d; end
        @(posedge clk); #2;
        if (wr) begin mdl[ad] = d; known[ad] = 1; end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_all();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state
        chk("R9 a_busy", a_busy, 0);
        chk("R9 b_busy", b_busy, 0);
        chk("R9 a_irq_n", a_irq_n, 1);
        chk("R9 b_irq_n", b_irq_n, 1);
        @(negedge clk); rst_n = 1;

        // R1: basic write then read on each port
        port_op(0, 1, 10'h055, 8'hA5);
        port_op(1, 0, 10'h055, 8'h00);
        chk("R1 B reads A write", b_rdata, 8'hA5);
        port_op(1, 1, 10'h066, 8'h3C);
        port_op(0, 0, 10'h066, 8'h00);
        chk("R1 A reads B write", a_rdata, 8'h3C);
        @(negedge clk); idle_all(); @(posedge clk); #2;
        chk("R1 read data holds", a_rdata, 8'h3C);

        // R2 / R1: random parallel traffic at distinct addresses
        for (int i = 0; i < 600; i++) begin
            int unsigned aa, bb, opa, opb;
            logic [7:0] da, db;
            aa = $urandom_range(0, 1021);
            bb = $urandom_range(0, 1020);
            if (bb >= aa) bb++;
            opa = $urandom_range(0, 2);
            opb = $urandom_range(0, 2);
            da = 8'($urandom); db = 8'($urandom);
            @(negedge clk);
            a_sel = (opa != 0); a_wr = (opa == 1); a_rd = (opa == 2);
            a_addr = 10'(aa); a_wdata = da;
            b_sel = (opb != 0); b_wr = (opb == 1); b_rd = (opb == 2);
            b_addr = 10'(bb); b_wdata = db;
            #1;
            if (opa != 0 && opb != 0) begin
                chk("R2 a_busy parallel", a_busy, 0);
                chk("R2 b_busy parallel", b_busy, 0);
            end
            @(posedge clk); #2;
            if (opa == 2 && known[aa]) chk("R2 A random read", a_rdata, expect_rd(10'(aa)));
            if (opb == 2 && known[bb]) chk("R2 B random read", b_rdata, expect_rd(10'(bb)));
            if (opa == 1) begin mdl[aa] = da; known[aa] = 1; end
            if (opb == 1) begin mdl[bb] = db; known[bb] = 1; end
        end

        // R4 / R5: tie on 0x010, both write; A wins, B waits two cycles
        @(negedge clk);
        idle_all();
        a_sel = 1; a_wr = 1; a_addr = 10'h010; a_wdata = 8'h11;
        b_sel = 1; b_wr = 1; b_addr = 10'h010; b_wdata = 8'h22;
        #1;
        chk("R4 tie a_busy", a_busy, 0);
        chk("R4 tie b_busy", b_busy, 1);
        chk("R10 not both busy", a_busy & b_busy, 0);
        @(negedge clk); #1;
        chk("R5 b_busy held", b_busy, 1);
        @(negedge clk);
        a_sel = 0; a_wr = 0;
        #1;
        chk("R5 b_busy released", b_busy, 0);
        @(posedge clk); #2;
        port_op(0, 0, 10'h010, 8'h00);
        chk("R5 loser write completed", a_rdata, 8'h22);

        // R3: B selects first, A arrives and loses
        port_op(0, 1, 10'h020, 8'h5A);
        @(negedge clk);
        idle_all();
        b_sel = 1; b_rd = 1; b_addr = 10'h020;
        @(negedge clk);
        a_sel = 1; a_wr = 1; a_addr = 10'h020; a_wdata = 8'h77;
        #1;
        chk("R3 a_busy", a_busy, 1);
        chk("R3 b_busy", b_busy, 0);
        @(posedge clk); #2;
        chk("R3 winner read old byte", b_rdata, 8'h5A);
        @(negedge clk);
        b_sel = 0; b_rd = 0;
        #1;
        chk("R5 a_busy released", a_busy, 0);
        @(posedge clk); #2;
        port_op(1, 0, 10'h020, 8'h00);
        chk("R3 held write landed", b_rdata, 8'h77);

        // R6 / R7: doorbell to B at 0x3FF
        port_op(0, 1, 10'h3FF, 8'hC3);
        chk("R6 b_irq_n low", b_irq_n, 0);
        chk("R6 a_irq_n untouched", a_irq_n, 1);
        port_op(0, 0, 10'h3FF, 8'h00);
        chk("R7 sender read keeps irq", b_irq_n, 0);
        port_op(1, 0, 10'h3FF, 8'h00);
        chk("R7 message byte", b_rdata, 8'hC3);
        chk("R7 receiver read clears", b_irq_n, 1);

        // R6 / R8: doorbell to A at 0x3FE
        port_op(1, 1, 10'h3FE, 8'h96);
        chk("R6 a_irq_n low", a_irq_n, 0);
        port_op(1, 0, 10'h3FE, 8'h00);
        chk("R8 sender read keeps irq", a_irq_n, 0);
        port_op(0, 0, 10'h3FE, 8'h00);
        chk("R8 message byte", a_rdata, 8'h96);
        chk("R8 receiver read clears", a_irq_n, 1);

        // R9: reset with both interrupts pending
        port_op(0, 1, 10'h3FF, 8'h01);
        port_op(1, 1, 10'h3FE, 8'h02);
        chk("R6 both pending", {a_irq_n, b_irq_n}, 2'b00);
        @(negedge clk); idle_all(); rst_n = 0;
        @(posedge clk); #2;
        chk("R9 irq after reset", {a_irq_n, b_irq_n}, 2'b11);
        @(negedge clk); rst_n = 1;
        port_op(1, 0, 10'h055, 8'h00);
        chk("R9 memory kept across reset", b_rdata, 8'hA5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule